// File: doc/BRIEF.md
# Serial Port FIFO Status Unit

This block holds the two data queues of a synchronous serial port and builds the 32-bit status word that software reads. The transmit queue is filled by the CPU and drained by the serial engine. The receive queue is filled by the serial engine and drained by the CPU. Both queues present their oldest entry at their read port without delay, so a pop removes the word that is shown on that port in the same cycle.

The status word reports the following:
- a not-full flag for the transmit queue and a not-empty flag for the receive queue;
- a busy flag;
- two threshold service requests;
- a sticky receive overrun flag, which software clears by writing a one to its bit;
- the two queue levels in 4-bit fields that wrap. The transmit level reads 0 both when the queue is empty and when it is full. The receive level reports the count minus one, so it reads 0xF both when the queue is empty and when it is full.

Software must use the flags to tell empty from full. The status word is combinational from the queue counts, the overrun register and the current control inputs.

Top module: `serial_fifo_status`

## Requirements
- R1: Bit 2 of the status word is 1 whenever the transmit queue holds fewer than 16 entries. A CPU push into a full transmit queue is ignored, even when the engine pops in the same cycle.
- R2: Bit 3 is 1 when the receive queue holds at least one entry. A pop from an empty queue of either kind is ignored.
- R3: Bit 4 (busy) equals the frame-active input while the port is enabled, and it is 0 while the port is disabled.
- R4: Bit 5 (transmit service request) is 1 when the port is enabled and the true transmit count (0 to 16) is less than or equal to the 4-bit transmit threshold. Otherwise it is 0.
- R5: Bit 6 (receive service request) is 1 when the port is enabled and the true receive count (0 to 16) is greater than or equal to the 4-bit receive threshold. Otherwise it is 0.
- R6: An engine push into a full receive queue drops the data. It sets bit 7 (overrun) on the next cycle, and `overrunIrq` follows bit 7.
- R7: A status write with the bit-7 value 1 clears the overrun flag on the next cycle. A write with value 0 leaves it unchanged. A new overrun in the same cycle as a clear leaves the flag set.
- R8: Bits 11:8 hold the transmit count modulo 16, so both an empty queue and a full queue read 0x0.
- R9: Bits 15:12 hold the receive count minus one, modulo 16, so both an empty queue and a full queue read 0xF.
- R10: After reset, with the port disabled, the status word is 0x0000F004. Bits 1:0 and 31:16 always read 0.
- R11: Each queue returns its data in push order. Its read port shows the oldest entry whenever the queue is not empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cpuTxPush | input | 1 | CPU write into the transmit queue |
| cpuTxData | input | DW | Data for the CPU write |
| engTxPop | input | 1 | Serial engine takes the transmit head |
| engTxData | output | DW | Transmit queue head |
| engRxPush | input | 1 | Serial engine writes a received word |
| engRxData | input | DW | Received word |
| cpuRxPop | input | 1 | CPU takes the receive head |
| cpuRxData | output | DW | Receive queue head |
| txThresh | input | 4 | Transmit service threshold |
| rxThresh | input | 4 | Receive service threshold |
| portEnable | input | 1 | Port enable |
| frameActive | input | 1 | A frame is in progress on the serial side |
| statusWrite | input | 1 | Software write to the status word |
| ovrWrBit | input | 1 | Bit 7 of the software write data |
| statusWord | output | 32 | Status word |
| overrunIrq | output | 1 | Overrun interrupt request |

## Verification
On every cycle, the assertions check these properties:
- the queues never overflow or underflow;
- a push into a full transmit queue leaves the queue full;
- an overrun sets the flag and a clear without a new overrun removes it, while a zero write keeps it;
- the service requests stay low while the port is disabled;
- the reserved bits stay zero.

Only the bench's scenarios can show the other behaviours. These are the wrapped level encodings at empty and full, the data order through each queue, the threshold boundaries, and a set that coincides with a clear. For these scenarios the bench compares every status field and both head words against a queue-based model on each clock.

// File: rtl/sfs_pkg.sv
package sfs_pkg;
  // Bit positions inside the status word; software decodes these.
  localparam int BIT_TNF = 2;
  localparam int BIT_RNE = 3;
  localparam int BIT_BSY = 4;
  localparam int BIT_TSR = 5;
  localparam int BIT_RSR = 6;
  localparam int BIT_OVR = 7;
  localparam int TXL_LO  = 8;
  localparam int RXL_LO  = 12;
  localparam int LVL_W   = 4;

  // Strobes from control to datapath: accepted queue operations.
  typedef struct packed {
    logic txWr;
    logic txRd;
    logic rxWr;
    logic rxRd;
  } fifoStrobe_t;
endpackage

// File: rtl/sfs_fifo.sv
module sfs_fifo #(
  parameter int DW    = 8,
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          wrEn,
  input  logic [DW-1:0] wrData,
  input  logic          rdEn,
  output logic [DW-1:0] rdData,
  output logic [CW-1:0] count
);
  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wrPtr, rdPtr;

  function automatic logic [AW-1:0] nextPtr(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (wrEn) mem[wrPtr] <= wrData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (wrEn) wrPtr <= nextPtr(wrPtr);
      if (rdEn) rdPtr <= nextPtr(rdPtr);
      count <= count + CW'(wrEn) - CW'(rdEn);
    end
  end

  assign rdData = mem[rdPtr];

  a_r1_no_overflow: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |-> (count < CW'(DEPTH) || rdEn));
  a_r2_no_underflow: assert property (@(posedge clk) disable iff (!rstN)
    rdEn |-> count != '0);
  a_r11_count_bound: assert property (@(posedge clk) disable iff (!rstN)
    count <= CW'(DEPTH));
endmodule

// File: rtl/sfs_datapath.sv
module sfs_datapath
  import sfs_pkg::*;
#(
  parameter int DW    = 8,
  parameter int DEPTH = 16,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  fifoStrobe_t   strobe,
  input  logic [DW-1:0] cpuTxData,
  input  logic [DW-1:0] engRxData,
  output logic [DW-1:0] engTxData,
  output logic [DW-1:0] cpuRxData,
  output logic [CW-1:0] txCount,
  output logic [CW-1:0] rxCount
);
  sfs_fifo #(.DW(DW), .DEPTH(DEPTH)) i_txFifo (
    .clk(clk), .rstN(rstN),
    .wrEn(strobe.txWr), .wrData(cpuTxData),
    .rdEn(strobe.txRd), .rdData(engTxData),
    .count(txCount)
  );

  sfs_fifo #(.DW(DW), .DEPTH(DEPTH)) i_rxFifo (
    .clk(clk), .rstN(rstN),
    .wrEn(strobe.rxWr), .wrData(engRxData),
    .rdEn(strobe.rxRd), .rdData(cpuRxData),
    .count(rxCount)
  );
endmodule

// File: rtl/sfs_control.sv
module sfs_control
  import sfs_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cpuTxPush,
  input  logic              engTxPop,
  input  logic              engRxPush,
  input  logic              cpuRxPop,
  input  logic [CW-1:0]     txCount,
  input  logic [CW-1:0]     rxCount,
  input  logic [LVL_W-1:0]  txThresh,
  input  logic [LVL_W-1:0]  rxThresh,
  input  logic              portEnable,
  input  logic              frameActive,
  input  logic              statusWrite,
  input  logic              ovrWrBit,
  output fifoStrobe_t       strobe,
  output logic [31:0]       statusWord,
  output logic              overrunIrq
);
  logic txFull, rxFull, txEmpty, rxEmpty;
  logic ovrSet, ovrClr, ovrFlag;
  logic [CW-1:0] txThrWide, rxThrWide, rxMinusOne;

  assign txFull  = (txCount == CW'(DEPTH));
  assign rxFull  = (rxCount == CW'(DEPTH));
  assign txEmpty = (txCount == '0);
  assign rxEmpty = (rxCount == '0);

  always_comb begin
    strobe.txWr = cpuTxPush && !txFull;
    strobe.txRd = engTxPop  && !txEmpty;
    strobe.rxWr = engRxPush && !rxFull;
    strobe.rxRd = cpuRxPop  && !rxEmpty;
  end

  assign ovrSet = engRxPush && rxFull;
  assign ovrClr = statusWrite && ovrWrBit;

  always_ff @(posedge clk) begin
    if (!rstN) ovrFlag <= 1'b0;
    else       ovrFlag <= ovrSet || (ovrFlag && !ovrClr);
  end
  assign overrunIrq = ovrFlag;

  assign txThrWide  = CW'(txThresh);
  assign rxThrWide  = CW'(rxThresh);
  assign rxMinusOne = rxCount - CW'(1);

  always_comb begin
    statusWord = '0;
    statusWord[BIT_TNF] = !txFull;
    statusWord[BIT_RNE] = !rxEmpty;
    statusWord[BIT_BSY] = portEnable && frameActive;
    statusWord[BIT_TSR] = portEnable && (txCount <= txThrWide);
    statusWord[BIT_RSR] = portEnable && (rxCount >= rxThrWide);
    statusWord[BIT_OVR] = ovrFlag;
    statusWord[TXL_LO +: LVL_W] = txCount[LVL_W-1:0];
    statusWord[RXL_LO +: LVL_W] = rxMinusOne[LVL_W-1:0];
  end

  a_r1_full_push_ignored: assert property (@(posedge clk) disable iff (!rstN)
    (cpuTxPush && txFull && !engTxPop) |=> txFull);
  a_r6_overrun_sets: assert property (@(posedge clk) disable iff (!rstN)
    (engRxPush && rxFull) |=> statusWord[BIT_OVR]);
  a_r7_clear_takes: assert property (@(posedge clk) disable iff (!rstN)
    (statusWrite && ovrWrBit && !(engRxPush && rxFull)) |=> !overrunIrq);
  a_r7_zero_write_keeps: assert property (@(posedge clk) disable iff (!rstN)
    (overrunIrq && !(statusWrite && ovrWrBit)) |=> overrunIrq);
  a_r4_disabled_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !portEnable |-> (!statusWord[BIT_TSR] && !statusWord[BIT_RSR] && !statusWord[BIT_BSY]));
  a_r10_reserved_zero: assert property (@(posedge clk) disable iff (!rstN)
    (statusWord[1:0] == 2'b00) && (statusWord[31:16] == 16'h0));
endmodule

// File: rtl/serial_fifo_status.sv
module serial_fifo_status
  import sfs_pkg::*;
#(
  parameter int DW    = 8,
  parameter int DEPTH = 16,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          cpuTxPush,
  input  logic [DW-1:0] cpuTxData,
  input  logic          engTxPop,
  output logic [DW-1:0] engTxData,
  input  logic          engRxPush,
  input  logic [DW-1:0] engRxData,
  input  logic          cpuRxPop,
  output logic [DW-1:0] cpuRxData,
  input  logic [3:0]    txThresh,
  input  logic [3:0]    rxThresh,
  input  logic          portEnable,
  input  logic          frameActive,
  input  logic          statusWrite,
  input  logic          ovrWrBit,
  output logic [31:0]   statusWord,
  output logic          overrunIrq
);
  fifoStrobe_t strobe;
  logic [CW-1:0] txCount, rxCount;

  sfs_control #(.DEPTH(DEPTH)) i_control (
    .clk(clk), .rstN(rstN),
    .cpuTxPush(cpuTxPush), .engTxPop(engTxPop),
    .engRxPush(engRxPush), .cpuRxPop(cpuRxPop),
    .txCount(txCount), .rxCount(rxCount),
    .txThresh(txThresh), .rxThresh(rxThresh),
    .portEnable(portEnable), .frameActive(frameActive),
    .statusWrite(statusWrite), .ovrWrBit(ovrWrBit),
    .strobe(strobe), .statusWord(statusWord), .overrunIrq(overrunIrq)
  );

  sfs_datapath #(.DW(DW), .DEPTH(DEPTH)) i_datapath (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .cpuTxData(cpuTxData), .engRxData(engRxData),
    .engTxData(engTxData), .cpuRxData(cpuRxData),
    .txCount(txCount), .rxCount(rxCount)
  );
endmodule

// File: tb/test_serial_fifo_status.sv
module test_serial_fifo_status;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cpuTxPush = 0, engTxPop = 0, engRxPush = 0, cpuRxPop = 0;
  logic [7:0] cpuTxData = 0, engRxData = 0;
  logic [7:0] engTxData, cpuRxData;
  logic [3:0] txThresh = 0, rxThresh = 0;
  logic portEnable = 0, frameActive = 0, statusWrite = 0, ovrWrBit = 0;
  logic [31:0] statusWord;
  logic overrunIrq;

  int nChecks = 0;
  int nFail = 0;
  bit finished = 0;

  logic [7:0] txQ[$];
  logic [7:0] rxQ[$];
  bit mOvr = 0;

  always #5 clk = ~clk;

  serial_fifo_status i_serial_fifo_status (
    .clk(clk), .rstN(rstN),
    .cpuTxPush(cpuTxPush), .cpuTxData(cpuTxData),
    .engTxPop(engTxPop), .engTxData(engTxData),
    .engRxPush(engRxPush), .engRxData(engRxData),
    .cpuRxPop(cpuRxPop), .cpuRxData(cpuRxData),
    .txThresh(txThresh), .rxThresh(rxThresh),
    .portEnable(portEnable), .frameActive(frameActive),
    .statusWrite(statusWrite), .ovrWrBit(ovrWrBit),
    .statusWord(statusWord), .overrunIrq(overrunIrq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // Compare every field against the model state plus current inputs.
  task automatic compareAll();
    int tc = txQ.size();
    int rc = rxQ.size();
    check("R1 tx not full",  statusWord[2], tc < 16);
    check("R2 rx not empty", statusWord[3], rc > 0);
    check("R3 busy",         statusWord[4], portEnable && frameActive);
    check("R4 tx service",   statusWord[5], portEnable && (tc <= int'(txThresh)));
    check("R5 rx service",   statusWord[6], portEnable && (rc >= int'(rxThresh)));
    check("R6 overrun bit",  statusWord[7], mOvr);
    check("R6 overrun irq",  overrunIrq, mOvr);
    check("R8 tx level",     statusWord[11:8], tc % 16);
    check("R9 rx level",     statusWord[15:12], (rc + 15) % 16);
    check("R10 reserved",    {statusWord[31:16], statusWord[1:0]}, 0);
    if (tc > 0) check("R11 tx head", engTxData, txQ[0]);
    if (rc > 0) check("R11 rx head", cpuRxData, rxQ[0]);
  endtask

  task automatic modelUpdate();
    bit txFull = (txQ.size() == 16);
    bit rxFull = (rxQ.size() == 16);
    bit setO = engRxPush && rxFull;
    if (engTxPop && txQ.size() > 0) void'(txQ.pop_front());
    if (cpuTxPush && !txFull) txQ.push_back(cpuTxData);
    if (cpuRxPop && rxQ.size() > 0) void'(rxQ.pop_front());
    if (engRxPush && !rxFull) rxQ.push_back(engRxData);
    mOvr = setO || (mOvr && !(statusWrite && ovrWrBit));
  endtask

  task automatic step(input bit tp, input bit tpop, input bit rp, input bit rpop,
                      input bit wr, input bit wb);
    @(negedge clk);
    cpuTxPush = tp; cpuTxData = 8'($urandom);
    engTxPop = tpop;
    engRxPush = rp; engRxData = 8'($urandom);
    cpuRxPop = rpop;
    statusWrite = wr; ovrWrBit = wb;
    #1;
    compareAll();
    modelUpdate();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nFail++;
      $display("FAIL watchdog expired");
      $display("  End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    #1;
    // R10: reset state with port disabled
    check("R10 reset word", statusWord, 32'h0000F004);
    check("R10 reset irq", overrunIrq, 1'b0);

    portEnable = 1; txThresh = 4; rxThresh = 8; frameActive = 1;
    // R1 R8 R4: fill transmit queue, 17th push ignored
    for (int i = 0; i < 17; i++) step(1, 0, 0, 0, 0, 0);
    // R1: push to full while engine pops: push still ignored
    step(1, 1, 0, 0, 0, 0);
    // R11 R2: drain transmit queue, extra pops on empty
    for (int i = 0; i < 18; i++) step(0, 1, 0, 0, 0, 0);
    // R5 R9 R6: fill receive queue, overrun on the 17th
    for (int i = 0; i < 17; i++) step(0, 0, 1, 0, 0, 0);
    // R7: zero write keeps the flag
    step(0, 0, 0, 0, 1, 0);
    step(0, 0, 0, 0, 0, 0);
    // R7: clear
    step(0, 0, 0, 0, 1, 1);
    step(0, 0, 0, 0, 0, 0);
    // R7: overrun and clear together, set wins
    step(0, 0, 1, 0, 1, 1);
    step(0, 0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 1, 1);
    // R11: drain receive queue in order, one extra pop
    for (int i = 0; i < 17; i++) step(0, 0, 0, 1, 0, 0);
    // R3 R4 R5: disabled port hides requests and busy
    portEnable = 0; rxThresh = 0;
    step(1, 0, 1, 0, 0, 0);
    step(0, 0, 0, 0, 0, 0);
    portEnable = 1;
    step(0, 0, 0, 0, 0, 0);
    // Mixed random traffic
    for (int i = 0; i < 4000; i++) begin
      if (i % 64 == 0) begin
        txThresh = 4'($urandom);
        rxThresh = 4'($urandom);
        portEnable = ($urandom_range(0, 7) != 0);
        frameActive = 1'($urandom);
      end
      step(($urandom_range(0, 9) < 6), ($urandom_range(0, 9) < 4),
           ($urandom_range(0, 9) < 5), ($urandom_range(0, 9) < 4),
           ($urandom_range(0, 15) == 0), 1'($urandom));
    end
    finished = 1;
    $display("  End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end
endmodule